// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general purpose I/O controller built from a parameterised number of 8-pin ports (one to seven). Every port owns a bank of registers, spaced 0x30 bytes apart. The bank holds the output value of each pin and a 2-bit drive mode for each pin: input, push-pull, open-drain or open-source. It also holds a pull-up disable mask, plus the interrupt registers: enable, event, force and edge polarity. It also returns the synchronised pad levels. The pad outputs (value, enable, pull-up request) go straight to an external pad ring.

Each pin's synchronised input is watched for one selectable edge, rising or falling. Detected edges are latched in a write-one-to-clear event register. The port's single level interrupt is the OR of its enabled events. A force register injects events for test. A global word at byte 0 reports the port count and a fixed version number. It also holds two enable bits, one of which requests the block clock.

The bus is a plain synchronous single-cycle interface: writes take effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` on the edge after `bus_rd` is sampled, and is zero whenever no read was requested.

Top module: `gpio_mport_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all pad enables are 0, all pad outputs are 0, all pull-up requests are 1, every port interrupt is 0, and all read/write register fields are 0.
- R2: The global word at byte 0x000 reads the port count in bits 15:9 and VERSION_ID in bits 8:2; these fields ignore writes. Bits 1:0 are writable. Bit 0 drives `clk_req` and bit 1 drives `sync_sel`, and writing 0 clears both.
- R3: Port p's bank sits at p×0x30. Its registers are at these offsets: 0x04 pad levels (read-only), 0x08 output data, 0x0C drive mode, 0x10 pull-up disable, 0x14 events, 0x18 interrupt enable, 0x1C force, 0x20 edge polarity. Any other offset, including a bank's offset 0x00 for p>0 and anything past the last bank, reads 0. Read data is valid one cycle after the read strobe and is 0 when no read is strobed.
- R4: Drive mode bits [2i+1:2i] set pin i: 00 input (enable never set), 01 push-pull (enable always set), 10 open-drain (enable set only while the output bit is 0), 11 open-source (enable set only while the output bit is 1).
- R5: Each pad output follows its output data bit in every drive mode.
- R6: A 1 in the pull-up disable register drops that pin's pull-up request. A 0 keeps the request at 1.
- R7: The pad-level register returns each pin's input after a two-flop synchroniser, whatever the pin's drive mode.
- R8: Edge polarity bit 1 records rising edges and bit 0 records falling edges. The opposite edge sets no event.
- R9: Edges are recorded whether or not the pin's interrupt is enabled. A port interrupt is high exactly when some event bit with its enable bit set is 1, one cycle after that condition arises.
- R10: Writing the event register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R11: A force bit at 1 sets its event bit on every clock, so a clear cannot remove that event. Writing 0 to the force register stops the injection, and the event can then be cleared.
- R12: Ports are independent: events, enables and forcing on one port never move another port's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pad_in | input | 8×NUM_PORTS | Pad input levels (asynchronous) |
| pad_out | output | 8×NUM_PORTS | Pad output values |
| pad_oe | output | 8×NUM_PORTS | Pad output enables |
| pad_pu | output | 8×NUM_PORTS | Pad pull-up requests |
| port_irq | output | NUM_PORTS | One level interrupt per port |
| clk_req | output | 1 | Block clock request |
| sync_sel | output | 1 | Sync-select enable |

## Verification
Register writes land at the clock edge that samples the strobe. Pad enables, outputs and pull-ups are derived from the written registers, so they are correct at the next falling edge. Read data is checked at the falling edge after the strobed rising edge. A pad change passes two synchroniser flops and one previous-value flop: the event bit sets on the third rising edge after the change, and the interrupt one edge later. The bench therefore waits five cycles after each pad change, and two cycles after each enable or force write, before it compares.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;
  localparam int DATA_W        = 16;
  localparam int PINS_PER_PORT = 8;
  localparam int BANK_STRIDE   = 48;
  localparam int OFS_W         = 6;

  localparam logic [OFS_W-1:0] OFS_PADLVL = 6'h04;
  localparam logic [OFS_W-1:0] OFS_DOUT   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_MODE   = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_PULLD  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_EVT    = 6'h14;
  localparam logic [OFS_W-1:0] OFS_IEN    = 6'h18;
  localparam logic [OFS_W-1:0] OFS_FORCE  = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_EDGE   = 6'h20;

  typedef enum logic [1:0] {
    DRV_INPUT = 2'b00,
    DRV_PUSH  = 2'b01,
    DRV_SINK  = 2'b10,
    DRV_SRC   = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/gpio_mport_sync.sv
module gpio_mport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_mport_pad.sv
module gpio_mport_pad
  import gpio_mport_pkg::*;
(
  input  logic [2*PINS_PER_PORT-1:0] mode,
  input  logic [PINS_PER_PORT-1:0]   dout,
  input  logic [PINS_PER_PORT-1:0]   pull_dis,
  output logic [PINS_PER_PORT-1:0]   pad_out,
  output logic [PINS_PER_PORT-1:0]   pad_oe,
  output logic [PINS_PER_PORT-1:0]   pad_pu
);
  for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
    drv_mode_e pin_mode;
    assign pin_mode = drv_mode_e'(mode[2*i+1:2*i]);
    always_comb begin
      unique case (pin_mode)
        DRV_PUSH: pad_oe[i] = 1'b1;
        DRV_SINK: pad_oe[i] = ~dout[i];
        DRV_SRC:  pad_oe[i] = dout[i];
        default:  pad_oe[i] = 1'b0;
      endcase
    end
  end

  assign pad_out = dout;
  assign pad_pu  = ~pull_dis;
endmodule

// File: rtl/gpio_mport_bank.sv
module gpio_mport_bank
  import gpio_mport_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [OFS_W-1:0]         offset,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [PINS_PER_PORT-1:0] pin_lvl,
  output logic [DATA_W-1:0]        rd_word,
  output logic [PINS_PER_PORT-1:0] pad_out,
  output logic [PINS_PER_PORT-1:0] pad_oe,
  output logic [PINS_PER_PORT-1:0] pad_pu,
  output logic                     irq
);
  localparam int P = PINS_PER_PORT;

  logic [P-1:0]   dout_q, pulld_q, evt_q, ien_q, force_q, rise_q, prev_q;
  logic [2*P-1:0] mode_q;
  logic [P-1:0]   edge_hit, evt_clr, evt_d;
  logic           irq_q;

  assign edge_hit = (rise_q & pin_lvl & ~prev_q) | (~rise_q & ~pin_lvl & prev_q);
  assign evt_clr  = (wr_en && offset == OFS_EVT) ? wdata[P-1:0] : '0;
  assign evt_d    = (evt_q & ~evt_clr) | edge_hit | force_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      mode_q  <= '0;
      pulld_q <= '0;
      ien_q   <= '0;
      force_q <= '0;
      rise_q  <= '0;
      evt_q   <= '0;
      prev_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q <= pin_lvl;
      evt_q  <= evt_d;
      irq_q  <= |(evt_q & ien_q);
      if (wr_en) begin
        unique case (offset)
          OFS_DOUT:  dout_q  <= wdata[P-1:0];
          OFS_MODE:  mode_q  <= wdata;
          OFS_PULLD: pulld_q <= wdata[P-1:0];
          OFS_IEN:   ien_q   <= wdata[P-1:0];
          OFS_FORCE: force_q <= wdata[P-1:0];
          OFS_EDGE:  rise_q  <= wdata[P-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (offset)
      OFS_PADLVL: rd_word[P-1:0] = pin_lvl;
      OFS_DOUT:   rd_word[P-1:0] = dout_q;
      OFS_MODE:   rd_word        = mode_q;
      OFS_PULLD:  rd_word[P-1:0] = pulld_q;
      OFS_EVT:    rd_word[P-1:0] = evt_q;
      OFS_IEN:    rd_word[P-1:0] = ien_q;
      OFS_FORCE:  rd_word[P-1:0] = force_q;
      OFS_EDGE:   rd_word[P-1:0] = rise_q;
      default:    rd_word        = '0;
    endcase
  end

  gpio_mport_pad pad_i (
    .mode     (mode_q),
    .dout     (dout_q),
    .pull_dis (pulld_q),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu)
  );

  assign irq = irq_q;
endmodule

// File: rtl/gpio_mport_ctrl.sv
module gpio_mport_ctrl
  import gpio_mport_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int VERSION_ID = 3,
  parameter int ADDR_W     = 9
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_wr,
  input  logic                               bus_rd,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pu,
  output logic [NUM_PORTS-1:0]               port_irq,
  output logic                               clk_req,
  output logic                               sync_sel
);
  localparam int NPIN = NUM_PORTS * PINS_PER_PORT;
  localparam int P    = PINS_PER_PORT;

  logic [NPIN-1:0]   pin_lvl;
  logic [DATA_W-1:0] port_rd [NUM_PORTS];
  logic [DATA_W-1:0] rd_mux, ctrl_word;
  logic [1:0]        ctrl_q;
  logic              ctrl_hit;

  assign ctrl_hit  = (bus_addr == '0);
  assign ctrl_word = {7'(NUM_PORTS), 7'(VERSION_ID), ctrl_q};

  always_ff @(posedge clk) begin
    if (rst)                    ctrl_q <= '0;
    else if (bus_wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];
  end
  assign clk_req  = ctrl_q[0];
  assign sync_sel = ctrl_q[1];

  gpio_mport_sync #(.W(NPIN)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pin_lvl)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int BASE = p * BANK_STRIDE;
    logic [ADDR_W-1:0] rel;
    logic              hit;
    logic [DATA_W-1:0] bank_rd;

    assign rel = bus_addr - ADDR_W'(BASE);
    assign hit = (bus_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(BANK_STRIDE));

    gpio_mport_bank bank_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr && hit),
      .offset  (rel[OFS_W-1:0]),
      .wdata   (bus_wdata),
      .pin_lvl (pin_lvl[p*P +: P]),
      .rd_word (bank_rd),
      .pad_out (pad_out[p*P +: P]),
      .pad_oe  (pad_oe[p*P +: P]),
      .pad_pu  (pad_pu[p*P +: P]),
      .irq     (port_irq[p])
    );

    assign port_rd[p] = hit ? bank_rd : '0;
  end

  always_comb begin
    rd_mux = ctrl_hit ? ctrl_word : '0;
    for (int p = 0; p < NUM_PORTS; p++) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_mport_chk.sv
module gpio_mport_chk #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [15:0]       wdata_lo,
  input logic [15:0]       bus_rdata,
  input logic [7:0]        oe_lo,
  input logic [7:0]        pu_lo,
  input logic              irq0,
  input logic              clk_req
);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(NUM_PORTS * 48);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (oe_lo == 8'h00 && pu_lo == 8'hFF && irq0 == 1'b0)); // R1

  AST_CLKREQ_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0) |=> (clk_req == $past(wdata_lo[0]))); // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 16'h0)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= END_ADDR) |=> (bus_rdata == 16'h0)); // R3

  AST_INPUT_MODE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(12) && wdata_lo == 16'h0) |=> (oe_lo == 8'h00)); // R4

  AST_PULL_DISABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(16) && wdata_lo[7:0] == 8'hFF) |=> (pu_lo == 8'h00)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(24) && wdata_lo[7:0] == 8'h00) |=> ##1 !irq0); // R9
endmodule

bind gpio_mport_ctrl gpio_mport_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .wdata_lo  (bus_wdata),
  .bus_rdata (bus_rdata),
  .oe_lo     (pad_oe[7:0]),
  .pu_lo     (pad_pu[7:0]),
  .irq0      (port_irq[0]),
  .clk_req   (clk_req)
);

// File: tb/gpio_mport_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_mport_ctrl_tb_top;
  localparam int NP = 2;
  localparam int VER = 3;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [15:0]   pad_in = '0;
  logic [15:0]   pad_out, pad_oe, pad_pu;
  logic [NP-1:0] port_irq;
  logic          clk_req, sync_sel;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mport_ctrl #(.NUM_PORTS(NP), .VERSION_ID(VER), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .port_irq(port_irq), .clk_req(clk_req),
    .sync_sel(sync_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [15:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_rd = 1'b1;
    @(negedge clk);
    data = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 pad_pu", 32'(pad_pu), 32'hFFFF);
    chk("R1 port_irq", 32'(port_irq), 32'h0);
    rd(12'h0C, v); chk("R1 mode reg", 32'(v), 32'h0);
    rd(0, v); chk("R2 id word", 32'(v), 32'((NP << 9) | (VER << 2)));
  endtask

  task automatic t_ctrl();
    logic [15:0] v;
    wr(0, 16'hFFFF);
    rd(0, v); chk("R2 ro fields kept", 32'(v), 32'((NP << 9) | (VER << 2) | 3));
    chk("R2 clk_req on", 32'(clk_req), 32'h1);
    chk("R2 sync_sel on", 32'(sync_sel), 32'h1);
    wr(0, 16'h0000);
    chk("R2 clk_req off", 32'(clk_req), 32'h0);
    chk("R2 sync_sel off", 32'(sync_sel), 32'h0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(12'h08, 16'h005A); rd(12'h08, v); chk("R3 dout port0", 32'(v), 32'h5A);
    wr(12'h20, 16'h00C3); rd(12'h20, v); chk("R3 edge port0", 32'(v), 32'hC3);
    wr(12'h20, 16'h0000); wr(12'h08, 16'h0000);
    rd(12'h24, v); chk("R3 unmapped 0x24", 32'(v), 32'h0);
    rd(12'h30, v); chk("R3 bank1 offset0", 32'(v), 32'h0);
    rd(12'h60, v); chk("R3 past last bank", 32'(v), 32'h0);
    wr(12'h38, 16'h0011); rd(12'h38, v); chk("R3 dout port1", 32'(v), 32'h11);
    rd(12'h08, v); chk("R3 port0 untouched", 32'(v), 32'h0);
    wr(12'h38, 16'h0000);
  endtask

  task automatic t_drive();
    logic [15:0] v;
    // pin0 push-pull, pin1 open-drain, pin2 open-source, pin3 input
    wr(12'h0C, 16'h0039);
    rd(12'h0C, v); chk("R3 mode readback", 32'(v), 32'h39);
    chk("R4 oe with dout=0", 32'(pad_oe[3:0]), 32'b0011);
    wr(12'h08, 16'h000F);
    chk("R4 oe with dout=1", 32'(pad_oe[3:0]), 32'b0101);
    chk("R5 pad_out", 32'(pad_out[7:0]), 32'h0F);
    wr(12'h3C, 16'h5555);
    chk("R4 port1 push-pull", 32'(pad_oe[15:8]), 32'hFF);
    chk("R5 port1 pad_out", 32'(pad_out[15:8]), 32'h00);
  endtask

  task automatic t_pull();
    wr(12'h40, 16'h00A5);
    chk("R6 port1 pull", 32'(pad_pu[15:8]), 32'h5A);
    chk("R6 port0 pull", 32'(pad_pu[7:0]), 32'hFF);
  endtask

  task automatic t_input();
    logic [15:0] v;
    @(negedge clk); pad_in = 16'hC3A5;
    idle(4);
    rd(12'h04, v); chk("R7 port0 levels", 32'(v), 32'hA5);
    rd(12'h34, v); chk("R7 port1 levels", 32'(v), 32'hC3);
    @(negedge clk); pad_in = 16'h0000;
    idle(5);
    wr(12'h14, 16'h00FF); wr(12'h44, 16'h00FF);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(12'h20, 16'h0001);             // pin0 rising, others falling
    @(negedge clk); pad_in[1] = 1'b1; // rising on falling-configured pin
    idle(5);
    rd(12'h14, v); chk("R8 wrong edge ignored", 32'(v), 32'h0);
    @(negedge clk); pad_in[0] = 1'b1;
    idle(5);
    rd(12'h14, v); chk("R8 rising recorded", 32'(v), 32'h01);
    chk("R9 masked no irq", 32'(port_irq), 32'h0);
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    rd(12'h14, v); chk("R8 falling ignored on rising pin", 32'(v), 32'h01);
    @(negedge clk); pad_in[1] = 1'b0;
    idle(5);
    rd(12'h14, v); chk("R8 falling recorded", 32'(v), 32'h03);
    wr(12'h18, 16'h0002);
    idle(2);
    chk("R9 irq port0", 32'(port_irq[0]), 32'h1);
    chk("R12 port1 quiet", 32'(port_irq[1]), 32'h0);
    wr(12'h14, 16'h0002);
    rd(12'h14, v); chk("R10 clear one bit", 32'(v), 32'h01);
    idle(1);
    chk("R9 irq drops", 32'(port_irq[0]), 32'h0);
    wr(12'h14, 16'h0000);
    rd(12'h14, v); chk("R10 zero write keeps", 32'(v), 32'h01);
  endtask

  task automatic t_force();
    logic [15:0] v;
    wr(12'h4C, 16'h0080);
    rd(12'h44, v); chk("R11 force sets", 32'(v), 32'h80);
    wr(12'h44, 16'h0080);
    rd(12'h44, v); chk("R11 clear blocked", 32'(v), 32'h80);
    wr(12'h48, 16'h0080);
    idle(2);
    chk("R11 forced irq", 32'(port_irq[1]), 32'h1);
    chk("R12 port0 unaffected", 32'(port_irq[0]), 32'h0);
    wr(12'h4C, 16'h0000);
    wr(12'h44, 16'h0080);
    rd(12'h44, v); chk("R11 clear after unforce", 32'(v), 32'h0);
    idle(1);
    chk("R11 irq released", 32'(port_irq[1]), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_map();
    t_drive();
    t_pull();
    t_input();
    t_edge();
    t_force();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule